// File: doc/BRIEF.md
# Refresh Slot and Status Flag Generator

This block tells the memory access scheduler which access slots of a scanline belong to memory refresh, so that no DMA transfer is issued in them. It also produces three bits of the status word: vertical blank, horizontal blank and odd field. Two horizontal resolutions are supported, a wide 40-cell mode and a narrow 32-cell mode. Each has its own set of refresh slots.

When a DMA transfer is running and its target is anything other than a write to main video memory, each mode blocks a second set of slots. These slots sit a few positions before the regular refresh slots.

The line number and the position within the line are derived from a frame cycle count by division by a fixed line length. The wide/narrow and PAL/NTSC mode bits are captured into a latched copy only at the start of a line. All timing decisions use that latched copy, never the live mode inputs.

Top module: `refresh_status_gen`

## Requirements
- R1: With the latched mode wide, `refresh_o` is high for slots 37, 69, 102, 133, 165 and 197, and for every slot of 210 or more. It is low for all other slots when the extra blocking of R2 is not active.
- R2: With the latched mode wide, `dma_run_i` high and `dma_code_i` not equal to 4'b0001 (the video memory write code), slots 34, 66, 99, 130, 162 and 194 also raise `refresh_o`.
- R3: With the latched mode narrow, `refresh_o` is high for slots 24, 56, 88, 120 and 152. Under the condition of R2, slots 21, 53, 85, 117 and 149 also raise it. All other slots are low.
- R4: The extra slots of R2 and R3 do not raise `refresh_o` when `dma_run_i` is low or when `dma_code_i` equals 4'b0001.
- R5: `vblank_o` is high when the line (frame cycle divided by 3420) is at least 224 with latched NTSC, or at least 240 with latched PAL.
- R6: `vblank_o` is also high when the frame cycle count is below 64 with latched wide mode, or below 80 with latched narrow mode.
- R7: `hblank_o` is high when the cycle within the line (frame cycle modulo 3420) is below 178 with latched wide mode, or below 222 with latched narrow mode.
- R8: `odd_o` equals `interlace_i` AND `odd_field_i`.
- R9: The latched wide and PAL bits take the values of `wide_i` and `pal_i` at a rising clock edge only when the cycle within the line is zero. Otherwise they hold. Reset sets both to zero (narrow, NTSC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_cyc_i | input | 21 | Master clock count since the start of the frame |
| slot_i | input | 8 | Access slot number within the line |
| wide_i | input | 1 | Live mode bit: 1 for 40-cell, 0 for 32-cell |
| pal_i | input | 1 | Live mode bit: 1 for PAL line count, 0 for NTSC |
| interlace_i | input | 1 | Interlace enabled |
| odd_field_i | input | 1 | Odd field currently displayed |
| dma_run_i | input | 1 | DMA transfer in progress |
| dma_code_i | input | 4 | Target code of the running DMA; 4'b0001 is a video memory write |
| refresh_o | output | 1 | Slot is blocked for DMA |
| vblank_o | output | 1 | Vertical blank status bit |
| hblank_o | output | 1 | Horizontal blank status bit |
| odd_o | output | 1 | Odd field status bit |

## Verification
The assertions check several properties on every cycle:
- the tail of wide-mode refresh slots;
- the absence of extra blocking while DMA is idle;
- the early-frame vertical blank;
- the odd-field gating;
- the rule that the latched mode holds away from line starts.

The exact slot lists in both modes, the line and cycle boundaries of both blanking bits under each latched mode, and the capture of the mode at a line start are shown only by the bench. It drives directed boundary values and seeded random positions, and compares the outputs with its own model.

// File: rtl/refresh_status_pkg.sv
package refresh_status_pkg;
  localparam int WIDE_BASE   [6] = '{37, 69, 102, 133, 165, 197};
  localparam int WIDE_EXTRA  [6] = '{34, 66, 99, 130, 162, 194};
  localparam int NARROW_BASE [5] = '{24, 56, 88, 120, 152};
  localparam int NARROW_EXTRA[5] = '{21, 53, 85, 117, 149};
  localparam int WIDE_TAIL   = 210;
  localparam logic [3:0] VRAM_WR_CODE = 4'b0001;
endpackage

// File: rtl/rsg_pos_latch.sv
module rsg_pos_latch #(
  parameter int FRAME_W   = 21,
  parameter int LINE_CLKS = 3420,
  parameter int LINE_W    = 9,
  localparam int LCYC_W   = $clog2(LINE_CLKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_cyc_i,
  input  logic               wide_i,
  input  logic               pal_i,
  output logic [LINE_W-1:0]  line_o,
  output logic [LCYC_W-1:0]  lcyc_o,
  output logic               line_start_o,
  output logic               wide_q_o,
  output logic               pal_q_o
);
  logic [FRAME_W-1:0] quot, rem;

  assign quot         = frame_cyc_i / FRAME_W'(LINE_CLKS);
  assign rem          = frame_cyc_i % FRAME_W'(LINE_CLKS);
  assign line_o       = LINE_W'(quot);
  assign lcyc_o       = LCYC_W'(rem);
  assign line_start_o = (rem == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q_o <= 1'b0;
      pal_q_o  <= 1'b0;
    end else if (line_start_o) begin
      wide_q_o <= wide_i;
      pal_q_o  <= pal_i;
    end
  end
endmodule

// File: rtl/rsg_refresh_match.sv
module rsg_refresh_match
  import refresh_status_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              wide_i,
  input  logic              dma_run_i,
  input  logic [3:0]        dma_code_i,
  output logic              refresh_o
);
  logic [5:0] wb_hit, wx_hit;
  logic [4:0] nb_hit, nx_hit;
  logic       dma_extra;

  for (genvar i = 0; i < 6; i++) begin : g_wide
    assign wb_hit[i] = (int'(slot_i) == WIDE_BASE[i]);
    assign wx_hit[i] = (int'(slot_i) == WIDE_EXTRA[i]);
  end
  for (genvar i = 0; i < 5; i++) begin : g_narrow
    assign nb_hit[i] = (int'(slot_i) == NARROW_BASE[i]);
    assign nx_hit[i] = (int'(slot_i) == NARROW_EXTRA[i]);
  end

  // extra blocking only for DMA targets other than video memory writes
  assign dma_extra = dma_run_i && (dma_code_i != VRAM_WR_CODE);

  always_comb begin
    if (wide_i)
      refresh_o = (|wb_hit) || (int'(slot_i) >= WIDE_TAIL) || (dma_extra && (|wx_hit));
    else
      refresh_o = (|nb_hit) || (dma_extra && (|nx_hit));
  end
endmodule

// File: rtl/rsg_status_bits.sv
module rsg_status_bits #(
  parameter int FRAME_W        = 21,
  parameter int LINE_W         = 9,
  parameter int LCYC_W         = 12,
  parameter int ACT_NTSC       = 224,
  parameter int ACT_PAL        = 240,
  parameter int EARLY_WIDE     = 64,
  parameter int EARLY_NARROW   = 80,
  parameter int HB_END_WIDE    = 178,
  parameter int HB_END_NARROW  = 222
) (
  input  logic [FRAME_W-1:0] frame_cyc_i,
  input  logic [LINE_W-1:0]  line_i,
  input  logic [LCYC_W-1:0]  lcyc_i,
  input  logic               wide_q_i,
  input  logic               pal_q_i,
  input  logic               interlace_i,
  input  logic               odd_field_i,
  output logic               vblank_o,
  output logic               hblank_o,
  output logic               odd_o
);
  logic late_line, early_frame;

  assign late_line   = int'(line_i) >= (pal_q_i ? ACT_PAL : ACT_NTSC);
  assign early_frame = int'(frame_cyc_i) < (wide_q_i ? EARLY_WIDE : EARLY_NARROW);
  assign vblank_o    = late_line || early_frame;
  assign hblank_o    = int'(lcyc_i) < (wide_q_i ? HB_END_WIDE : HB_END_NARROW);
  assign odd_o       = interlace_i && odd_field_i;
endmodule

// File: rtl/refresh_status_gen.sv
module refresh_status_gen #(
  parameter int FRAME_W   = 21,
  parameter int SLOT_W    = 8,
  parameter int LINE_CLKS = 3420,
  parameter int LINE_W    = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_cyc_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic               wide_i,
  input  logic               pal_i,
  input  logic               interlace_i,
  input  logic               odd_field_i,
  input  logic               dma_run_i,
  input  logic [3:0]         dma_code_i,
  output logic               refresh_o,
  output logic               vblank_o,
  output logic               hblank_o,
  output logic               odd_o
);
  localparam int LCYC_W = $clog2(LINE_CLKS);

  logic [LINE_W-1:0] line;
  logic [LCYC_W-1:0] lcyc;
  logic              line_start, wide_q, pal_q;

  rsg_pos_latch #(.FRAME_W(FRAME_W), .LINE_CLKS(LINE_CLKS), .LINE_W(LINE_W)) u_pos (
    .clk_i, .rst_ni, .frame_cyc_i, .wide_i, .pal_i,
    .line_o(line), .lcyc_o(lcyc), .line_start_o(line_start),
    .wide_q_o(wide_q), .pal_q_o(pal_q)
  );

  rsg_refresh_match #(.SLOT_W(SLOT_W)) u_match (
    .slot_i, .wide_i(wide_q), .dma_run_i, .dma_code_i, .refresh_o
  );

  rsg_status_bits #(.FRAME_W(FRAME_W), .LINE_W(LINE_W), .LCYC_W(LCYC_W)) u_stat (
    .frame_cyc_i, .line_i(line), .lcyc_i(lcyc), .wide_q_i(wide_q), .pal_q_i(pal_q),
    .interlace_i, .odd_field_i, .vblank_o, .hblank_o, .odd_o
  );
endmodule

// File: rtl/refresh_status_gen_chk.sv
module refresh_status_gen_chk #(
  parameter int FRAME_W = 21,
  parameter int SLOT_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [FRAME_W-1:0] frame_cyc_i,
  input logic [SLOT_W-1:0]  slot_i,
  input logic               interlace_i,
  input logic               odd_field_i,
  input logic               dma_run_i,
  input logic               refresh_o,
  input logic               vblank_o,
  input logic               odd_o,
  input logic               line_start,
  input logic               wide_q
);
  assert_tail_slots_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_q && int'(slot_i) >= 210) |-> refresh_o);

  assert_idle_no_extra_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_run_i && ((wide_q && int'(slot_i) == 34) || (!wide_q && int'(slot_i) == 21))) |-> !refresh_o);

  assert_early_vblank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(frame_cyc_i) < 64) |-> vblank_o);

  assert_odd_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !interlace_i |-> !odd_o);

  assert_mode_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start |=> $stable(wide_q));

  assert_odd_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interlace_i && odd_field_i) |-> odd_o);
endmodule

bind refresh_status_gen refresh_status_gen_chk #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_chk (
  .clk_i, .rst_ni, .frame_cyc_i, .slot_i, .interlace_i, .odd_field_i, .dma_run_i,
  .refresh_o, .vblank_o, .odd_o, .line_start, .wide_q
);

// File: tb/refresh_status_gen_bench.sv
`timescale 1ns/1ps
module refresh_status_gen_bench;
  localparam int LINE = 3420;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [20:0] frame_cyc_i = '0;
  logic [7:0]  slot_i = '0;
  logic        wide_i = 1'b0, pal_i = 1'b0, interlace_i = 1'b0, odd_field_i = 1'b0;
  logic        dma_run_i = 1'b0;
  logic [3:0]  dma_code_i = '0;
  logic        refresh_o, vblank_o, hblank_o, odd_o;

  int errors = 0;
  int checks = 0;
  logic m_wide = 1'b0, m_pal = 1'b0;

  always #2 clk_i = ~clk_i;

  refresh_status_gen u_refresh_status_gen (.*);

  function automatic logic exp_refresh(int s, logic w, logic run, logic [3:0] code);
    logic ex = run && (code != 4'b0001);
    if (w)
      return (s == 37 || s == 69 || s == 102 || s == 133 || s == 165 || s == 197 || s >= 210) ||
             (ex && (s == 34 || s == 66 || s == 99 || s == 130 || s == 162 || s == 194));
    return (s == 24 || s == 56 || s == 88 || s == 120 || s == 152) ||
           (ex && (s == 21 || s == 53 || s == 85 || s == 117 || s == 149));
  endfunction

  function automatic logic exp_vblank(int c, logic w, logic p);
    return ((c / LINE) >= (p ? 240 : 224)) || (c < (w ? 64 : 80));
  endfunction

  function automatic logic exp_hblank(int c, logic w);
    return (c % LINE) < (w ? 178 : 222);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (cyc=%0d slot=%0d)", req, act, exp, frame_cyc_i, slot_i);
    end
  endtask

  task automatic apply(int cyc, int slot, logic w, logic p, logic il, logic od,
                       logic run, logic [3:0] code, string rtag);
    @(negedge clk_i);
    frame_cyc_i = 21'(cyc); slot_i = 8'(slot); wide_i = w; pal_i = p;
    interlace_i = il; odd_field_i = od; dma_run_i = run; dma_code_i = code;
    @(posedge clk_i);
    if (cyc % LINE == 0) begin m_wide = w; m_pal = p; end
    #1;
    chk(rtag, refresh_o, exp_refresh(slot, m_wide, run, code));
    chk("R5,R6", vblank_o, exp_vblank(cyc, m_wide, m_pal));
    chk("R7", hblank_o, exp_hblank(cyc, m_wide));
    chk("R8", odd_o, il && od);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd5417;
    void'($urandom(seed));
    // R9 reset state: narrow, NTSC latched
    wide_i = 1'b1; slot_i = 8'd24; #3;
    chk("R9", refresh_o, 1'b1);
    chk("R9", vblank_o, 1'b1);
    chk("R9", hblank_o, 1'b1);
    @(negedge clk_i); rst_ni = 1'b1;

    // latch wide/NTSC at a line start
    apply(LINE * 10, 37, 1, 0, 0, 0, 0, 4'h1, "R1");
    apply(LINE * 10 + 5, 209, 1, 0, 0, 0, 0, 4'h1, "R1");
    apply(LINE * 10 + 6, 210, 1, 0, 0, 0, 0, 4'h1, "R1");
    apply(LINE * 10 + 7, 255, 1, 0, 0, 0, 0, 4'h1, "R1");
    apply(LINE * 10 + 8, 34, 1, 0, 0, 0, 1, 4'h3, "R2");
    apply(LINE * 10 + 9, 194, 1, 0, 0, 0, 1, 4'h5, "R2");
    apply(LINE * 10 + 10, 34, 1, 0, 0, 0, 1, 4'h1, "R4");
    apply(LINE * 10 + 11, 99, 1, 0, 0, 0, 0, 4'h3, "R4");
    // R9: mode change away from line start is ignored (still wide)
    apply(LINE * 10 + 12, 210, 0, 1, 0, 0, 0, 4'h1, "R9");
    apply(LINE * 224 - 1, 0, 1, 0, 0, 0, 0, 4'h1, "R5");
    apply(LINE * 224 + 1, 0, 1, 0, 0, 0, 0, 4'h1, "R5");
    apply(LINE * 11 + 177, 0, 1, 0, 1, 1, 0, 4'h1, "R7");
    apply(LINE * 11 + 178, 0, 1, 0, 1, 0, 0, 4'h1, "R7");
    apply(63, 0, 1, 0, 0, 0, 0, 4'h1, "R6");
    apply(64, 0, 1, 0, 0, 0, 0, 4'h1, "R6");
    // latch narrow/PAL
    apply(LINE * 20, 24, 0, 1, 0, 0, 0, 4'h1, "R3");
    apply(LINE * 20 + 1, 21, 0, 1, 0, 0, 1, 4'h2, "R3");
    apply(LINE * 20 + 2, 149, 0, 1, 0, 0, 1, 4'h0, "R3");
    apply(LINE * 20 + 3, 21, 0, 1, 0, 0, 1, 4'h1, "R4");
    apply(LINE * 20 + 4, 210, 0, 1, 0, 0, 0, 4'h1, "R3");
    apply(LINE * 20 + 221, 37, 0, 1, 0, 0, 0, 4'h1, "R7");
    apply(LINE * 20 + 222, 37, 0, 1, 0, 0, 0, 4'h1, "R7");
    apply(LINE * 239 + 5, 0, 0, 1, 0, 0, 0, 4'h1, "R5");
    apply(LINE * 240 + 5, 0, 0, 1, 0, 0, 0, 4'h1, "R5");
    apply(79, 0, 0, 1, 0, 0, 0, 4'h1, "R6");
    apply(80, 0, 0, 1, 0, 0, 0, 4'h1, "R6");

    for (int i = 0; i < 600; i++) begin
      int c = int'($urandom % (313 * LINE));
      if ($urandom % 6 == 0) c = (c / LINE) * LINE;
      apply(c, int'($urandom % 256), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 4'($urandom), "R1,R2,R3,R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule